// File: doc/BRIEF.md
# NAND Address-Mapped Control Bridge

This block connects a simple request/ready memory bus to one or two raw NAND flash dies on each of up to four primary chip selects. Software never programs the command-latch or address-latch lines through registers. Instead, address bits of each data-space access pick the line. Address bit 4 raises the command latch, and address bit 3 raises the address latch. A parameter-chosen higher address bit selects the second die, which sits behind the same primary chip select.

One bus access of byte, halfword or word size is turned into one to four NAND cycles with no software involvement. This depends on the device width set in the mode register, which may be 8 or 16 bits. Each NAND cycle has three phases: a setup phase, an active-low write or read strobe, and a hold phase. The length of each phase is programmable. Read data is assembled little-endian. A small register space holds the mode, the timing and a status register. Bit 0 of the status register shows the wire-AND ready/busy line shared by all dies.

Top module: `nand_addr_bridge`

## Requirements
- R1: An access whose address has bit 3 set and bit 4 clear holds nand_ale at 1 for every NAND cycle of that access; otherwise nand_ale stays 0.
- R2: An access whose address has bit 4 set holds nand_cle at 1 for every NAND cycle of that access. When bits 3 and 4 are both set, nand_cle is 1 and nand_ale is 0.
- R3: Address bit DIE_BIT (default 12) set drives nand_die1_ce_n low for the whole access. Clear leaves it high.
- R4: Address bits 1:0 are ignored. The number of NAND cycles depends on bus_size (0 byte, 1 halfword, 2 word) and the device width. An 8-bit device takes 1, 2 or 4 cycles. A 16-bit device takes 1, 1 or 2 cycles.
- R5: NAND cycle k of a write drives wdata[8k+7:8k] on nand_dout[7:0] with the upper bits 0 (8-bit device), or wdata[16k+15:16k] (16-bit device). A read places nand_din[7:0] (or nand_din[15:0]) of cycle k at the same position of bus_rdata, and bits above the access size read 0.
- R6: With timing fields S, P, H, each NAND cycle has S+1 setup cycles, P+1 cycles with the strobe low and H+1 hold cycles. bus_ready is a single-cycle pulse, n*(S+P+H+3)+1 cycles after the request is first sampled, where n is the number of NAND cycles.
- R7: Status register (index 2) bit 0 reads nand_wait after a two-flop synchronizer; 1 means ready.
- R8: Mode register (index 0) bit n enables chip select n for NAND data accesses. An access to a disabled chip select produces no strobe or chip select, completes in 1 cycle and reads 0.
- R9: After reset, all strobes and chip selects are inactive (high), nand_cle, nand_ale, nand_doe and bus_ready are 0, and the mode and timing registers read 0.
- R10: Register accesses (bus_cfg=1, index in address bits 3:2) complete in 1 cycle. Index 0 holds the enables in bits NCS-1:0 and the 16-bit width flag in bit 8. Index 1 holds S in bits 3:0, P in bits 7:4 and H in bits 11:8. Writes to the status register are ignored.
- R11: During a NAND access, only nand_ce_n[bus_cs] is low, and it stays low through every strobe of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until bus_ready |
| bus_cfg | input | 1 | 1 selects register space, 0 NAND data space |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_cs | input | CSW | Primary chip select number |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | NCS | Primary chip selects, active low |
| nand_die1_ce_n | output | 1 | Second-die select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 16 | Data to device |
| nand_doe | output | 1 | Data output enable |
| nand_din | input | 16 | Data from device |
| nand_wait | input | 1 | Shared ready/busy, 1 = ready |

## Verification
Register and disabled-select accesses raise bus_ready one cycle after the request is first sampled. A NAND access raises it n*(S+P+H+3)+1 cycles after, where n is the number of NAND cycles. The bench counts falling clock edges from the request to the ready pulse and compares the count against this formula for several timing settings. Each NAND cycle is logged at the rising edge of its strobe, which is when data, latch lines and selects are stable. Strobe width is counted as low samples taken on the falling clock edge. The status bit is read only after the synchronizer's two cycles plus margin have passed.

// File: rtl/nab_pkg.sv
package nab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
  } nab_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] RG_MODE = 2'd0;
  localparam logic [1:0] RG_TIME = 2'd1;
  localparam logic [1:0] RG_STAT = 2'd2;

  typedef struct packed {
    logic       we;
    logic       cle;
    logic       ale;
    logic       hi;
    logic [1:0] size;
  } nab_req_t;
endpackage

// File: rtl/nab_regs.sv
module nab_regs #(
  parameter int NCS = 4,
  parameter int TW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    idx,
  input  logic [31:0]   wdata,
  input  logic          nand_wait,
  output logic [NCS-1:0] cs_en,
  output logic          wide,
  output logic [TW-1:0] t_setup,
  output logic [TW-1:0] t_strobe,
  output logic [TW-1:0] t_hold,
  output logic [31:0]   rdata
);
  import nab_pkg::*;

  localparam int WIDE_BIT = 8;

  logic [2:0] wsync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_en    <= '0;
      wide     <= 1'b0;
      t_setup  <= '0;
      t_strobe <= '0;
      t_hold   <= '0;
      wsync_q  <= '0;
    end else begin
      wsync_q <= {wsync_q[1:0], nand_wait};
      if (wr_en && idx == RG_MODE) begin
        cs_en <= wdata[NCS-1:0];
        wide  <= wdata[WIDE_BIT];
      end
      if (wr_en && idx == RG_TIME) begin
        t_setup  <= wdata[TW-1:0];
        t_strobe <= wdata[2*TW-1:TW];
        t_hold   <= wdata[3*TW-1:2*TW];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      RG_MODE: begin
        rdata[NCS-1:0]  = cs_en;
        rdata[WIDE_BIT] = wide;
      end
      RG_TIME: rdata[3*TW-1:0] = {t_hold, t_strobe, t_setup};
      RG_STAT: rdata[0] = wsync_q[1];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/nab_lanes.sv
module nab_lanes (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic        wide,
  input  logic [1:0]  idx_n,
  input  logic [1:0]  idx_q,
  input  logic        cap,
  input  logic [15:0] din,
  output logic [1:0]  last_idx,
  output logic [15:0] dout_q,
  output logic [31:0] acc_q
);
  import nab_pkg::*;

  logic [1:0]  size_q;
  logic [31:0] wdata_q;
  logic [31:0] wdata_n;
  logic [15:0] slice;

  assign wdata_n = load ? wdata_i : wdata_q;

  always_comb begin
    case (size_q)
      SZ_BYTE: last_idx = 2'd0;
      SZ_HALF: last_idx = wide ? 2'd0 : 2'd1;
      default: last_idx = wide ? 2'd1 : 2'd3;
    endcase
  end

  always_comb begin
    if (wide) slice = wdata_n[{idx_n[0], 4'b0000} +: 16];
    else      slice = {8'h00, wdata_n[{idx_n, 3'b000} +: 8]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= SZ_BYTE;
      wdata_q <= '0;
      dout_q  <= '0;
      acc_q   <= '0;
    end else begin
      dout_q <= slice;
      if (load) begin
        size_q  <= size_i;
        wdata_q <= wdata_i;
        acc_q   <= '0;
      end else if (cap) begin
        if (wide) acc_q[{idx_q[0], 4'b0000} +: 16] <= din;
        else      acc_q[{idx_q, 3'b000} +: 8]      <= din[7:0];
      end
    end
  end
endmodule

// File: rtl/nab_seq.sv
module nab_seq #(
  parameter int NCS = 4,
  parameter int TW  = 4,
  parameter int CSW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_nand,
  input  logic              go_quick,
  input  nab_pkg::nab_req_t req_i,
  input  logic [CSW-1:0]    cs_i,
  input  logic [TW-1:0]     t_setup,
  input  logic [TW-1:0]     t_strobe,
  input  logic [TW-1:0]     t_hold,
  input  logic [1:0]        last_idx,
  output logic              idle,
  output logic              finish,
  output logic              cap,
  output logic              rd_access,
  output logic [1:0]        idx_n,
  output logic [1:0]        idx_q,
  output logic              ready_q,
  output logic [NCS-1:0]    ce_n_q,
  output logic              die1_n_q,
  output logic              cle_q,
  output logic              ale_q,
  output logic              we_n_q,
  output logic              re_n_q,
  output logic              doe_q
);
  import nab_pkg::*;

  nab_state_e     st_q, st_d;
  logic [TW-1:0]  cnt_q, cnt_d;
  nab_req_t       req_q, req_n;
  logic [CSW-1:0] cs_q, cs_n;
  logic           active_d;

  assign idle      = (st_q == ST_IDLE);
  assign req_n     = idle ? req_i : req_q;
  assign cs_n      = idle ? cs_i : cs_q;
  assign cap       = (st_q == ST_STROBE) && (cnt_q == '0) && !req_q.we;
  assign finish    = (st_q == ST_HOLD) && (cnt_q == '0) && (idx_q == last_idx);
  assign rd_access = !req_q.we;
  assign active_d  = (st_d == ST_SETUP) || (st_d == ST_STROBE) || (st_d == ST_HOLD);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_n = idx_q;
    case (st_q)
      ST_IDLE: begin
        if (go_nand) begin
          st_d  = ST_SETUP;
          cnt_d = t_setup;
          idx_n = 2'd0;
        end else if (go_quick) begin
          st_d = ST_DONE;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = ST_STROBE;
          cnt_d = t_strobe;
        end else cnt_d = cnt_q - TW'(1);
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          st_d  = ST_HOLD;
          cnt_d = t_hold;
        end else cnt_d = cnt_q - TW'(1);
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          if (idx_q == last_idx) st_d = ST_DONE;
          else begin
            st_d  = ST_SETUP;
            cnt_d = t_setup;
            idx_n = idx_q + 2'd1;
          end
        end else cnt_d = cnt_q - TW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      req_q    <= '0;
      cs_q     <= '0;
      ready_q  <= 1'b0;
      ce_n_q   <= '1;
      die1_n_q <= 1'b1;
      cle_q    <= 1'b0;
      ale_q    <= 1'b0;
      we_n_q   <= 1'b1;
      re_n_q   <= 1'b1;
      doe_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_n;
      req_q    <= req_n;
      cs_q     <= cs_n;
      ready_q  <= (st_d == ST_DONE);
      ce_n_q   <= active_d ? ~(NCS'(1) << cs_n) : '1;
      die1_n_q <= !(active_d && req_n.hi);
      cle_q    <= active_d && req_n.cle;
      ale_q    <= active_d && req_n.ale;
      we_n_q   <= !((st_d == ST_STROBE) && req_n.we);
      re_n_q   <= !((st_d == ST_STROBE) && !req_n.we);
      doe_q    <= active_d && req_n.we;
    end
  end

  a_r11_ce_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ce_n_q));
  a_r11_ce_under_strobe: assert property (@(posedge clk) disable iff (rst)
    (!we_n_q || !re_n_q) |-> (ce_n_q != '1));
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> !ready_q);
  a_r2_cle_over_ale: assert property (@(posedge clk) disable iff (rst)
    !(cle_q && ale_q));
endmodule

// File: rtl/nand_addr_bridge.sv
module nand_addr_bridge #(
  parameter int NCS     = 4,
  parameter int AW      = 16,
  parameter int TW      = 4,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4,
  parameter int DIE_BIT = 12,
  localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_req,
  input  logic           bus_cfg,
  input  logic           bus_we,
  input  logic [1:0]     bus_size,
  input  logic [CSW-1:0] bus_cs,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           bus_ready,
  output logic [NCS-1:0] nand_ce_n,
  output logic           nand_die1_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [15:0]    nand_dout,
  output logic           nand_doe,
  input  logic [15:0]    nand_din,
  input  logic           nand_wait
);
  import nab_pkg::*;

  logic           idle, finish, cap, rd_access;
  logic           accept, go_cfg, go_nand, go_quick;
  logic [1:0]     idx_n, idx_q, last_idx;
  logic [NCS-1:0] cs_en;
  logic           wide;
  logic [TW-1:0]  t_setup, t_strobe, t_hold;
  logic [31:0]    reg_rdata, acc_q;
  logic [31:0]    rdata_q;
  nab_req_t       req;

  assign accept   = idle && bus_req;
  assign go_cfg   = accept && bus_cfg;
  assign go_nand  = accept && !bus_cfg && cs_en[bus_cs];
  assign go_quick = accept && !go_nand;

  assign req.we   = bus_we;
  assign req.cle  = bus_addr[CLE_BIT];
  assign req.ale  = bus_addr[ALE_BIT] && !bus_addr[CLE_BIT];
  assign req.hi   = bus_addr[DIE_BIT];
  assign req.size = bus_size;

  nab_regs #(.NCS(NCS), .TW(TW)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(go_cfg && bus_we), .idx(bus_addr[3:2]), .wdata(bus_wdata),
    .nand_wait(nand_wait),
    .cs_en(cs_en), .wide(wide),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold),
    .rdata(reg_rdata)
  );

  nab_lanes lanes_i (
    .clk(clk), .rst(rst),
    .load(go_nand), .size_i(bus_size), .wdata_i(bus_wdata), .wide(wide),
    .idx_n(idx_n), .idx_q(idx_q), .cap(cap), .din(nand_din),
    .last_idx(last_idx), .dout_q(nand_dout), .acc_q(acc_q)
  );

  nab_seq #(.NCS(NCS), .TW(TW), .CSW(CSW)) seq_i (
    .clk(clk), .rst(rst),
    .go_nand(go_nand), .go_quick(go_quick), .req_i(req), .cs_i(bus_cs),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold),
    .last_idx(last_idx),
    .idle(idle), .finish(finish), .cap(cap), .rd_access(rd_access),
    .idx_n(idx_n), .idx_q(idx_q),
    .ready_q(bus_ready), .ce_n_q(nand_ce_n), .die1_n_q(nand_die1_ce_n),
    .cle_q(nand_cle), .ale_q(nand_ale),
    .we_n_q(nand_we_n), .re_n_q(nand_re_n), .doe_q(nand_doe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (accept) begin
      rdata_q <= (go_cfg && !bus_we) ? reg_rdata : '0;
    end else if (finish && rd_access) begin
      rdata_q <= acc_q;
    end
  end

  assign bus_rdata = rdata_q;

  a_r8_disabled_quick: assert property (@(posedge clk) disable iff (rst)
    (accept && !bus_cfg && !cs_en[bus_cs]) |=> (bus_ready && nand_ce_n == '1));
  a_r5_dout_steady: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dout));
  a_r10_cfg_quick: assert property (@(posedge clk) disable iff (rst)
    go_cfg |=> bus_ready);
endmodule

// File: tb/nand_addr_bridge_tb_top.sv
module nand_addr_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_cfg = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd0, bus_cs = 2'd0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ready;
  logic [3:0]  nand_ce_n;
  logic        nand_die1_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic [15:0] nand_dout;
  logic [15:0] nand_din = '0;
  logic        nand_wait = 1'b0;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  nand_addr_bridge dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_cfg(bus_cfg), .bus_we(bus_we),
    .bus_size(bus_size), .bus_cs(bus_cs), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .nand_ce_n(nand_ce_n), .nand_die1_ce_n(nand_die1_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dout(nand_dout), .nand_doe(nand_doe),
    .nand_din(nand_din), .nand_wait(nand_wait)
  );

  // device model: log each NAND cycle at strobe release, feed read data
  int          cyc_n = 0;
  int          low_n = 0;
  int          rd_ptr = 0;
  logic [15:0] log_d [8];
  logic        log_cle [8], log_ale [8], log_die [8];
  logic [3:0]  log_ce [8];
  logic [15:0] rd_pat [4];

  always @(posedge nand_we_n or posedge nand_re_n) begin
    if (!rst && cyc_n < 8) begin
      log_d[cyc_n]   = nand_dout;
      log_cle[cyc_n] = nand_cle;
      log_ale[cyc_n] = nand_ale;
      log_die[cyc_n] = nand_die1_ce_n;
      log_ce[cyc_n]  = nand_ce_n;
    end
    if (!rst) cyc_n++;
  end

  always @(negedge nand_re_n) begin
    nand_din = rd_pat[rd_ptr % 4];
    rd_ptr++;
  end

  always @(negedge clk) if (!rst && (!nand_we_n || !nand_re_n)) low_n++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic cfg, input logic we, input logic [1:0] size,
                        input logic [1:0] cs, input logic [15:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int lat);
    @(negedge clk);
    cyc_n = 0; low_n = 0; rd_ptr = 0;
    bus_cfg = cfg; bus_we = we; bus_size = size; bus_cs = cs;
    bus_addr = addr; bus_wdata = wd; bus_req = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ready && lat < 2000);
    rd = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic cfg_wr(input logic [1:0] idx, input logic [31:0] d);
    logic [31:0] r; int l;
    access(1'b1, 1'b1, 2'd2, 2'd0, {12'h0, idx, 2'b00}, d, r, l);
  endtask

  task automatic t_reset();
    logic [31:0] r; int l;
    chk(nand_we_n && nand_re_n && nand_die1_ce_n, "R9 strobes idle", {29'h0, nand_we_n, nand_re_n, nand_die1_ce_n}, 32'h7);
    chk(nand_ce_n == 4'hF, "R9 ce_n idle", {28'h0, nand_ce_n}, 32'hF);
    chk(!nand_cle && !nand_ale && !nand_doe && !bus_ready, "R9 latches/doe/ready", {28'h0, nand_cle, nand_ale, nand_doe, bus_ready}, 32'h0);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0000, 32'h0, r, l);
    chk(r == 32'h0, "R9 mode after reset", r, 32'h0);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0004, 32'h0, r, l);
    chk(r == 32'h0, "R9 timing after reset", r, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] r; int l;
    access(1'b1, 1'b1, 2'd2, 2'd0, 16'h0004, 32'hFFFF_F2A5, r, l);
    chk(l == 1, "R10 cfg write latency", l, 1);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0004, 32'h0, r, l);
    chk(r == 32'h0000_02A5, "R10 timing readback", r, 32'h0000_02A5);
    access(1'b1, 1'b1, 2'd2, 2'd0, 16'h0000, 32'h0000_0109, r, l);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0000, 32'h0, r, l);
    chk(r == 32'h0000_0109, "R10 mode readback", r, 32'h0000_0109);
    access(1'b1, 1'b1, 2'd2, 2'd0, 16'h0008, 32'hFFFF_FFFF, r, l);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0008, 32'h0, r, l);
    chk(r == 32'h0, "R10 status write ignored", r, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] r; int l;
    nand_wait = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0008, 32'h0, r, l);
    chk(r == 32'h1, "R7 status ready", r, 32'h1);
    nand_wait = 1'b0;
    repeat (4) @(negedge clk);
    access(1'b1, 1'b0, 2'd2, 2'd0, 16'h0008, 32'h0, r, l);
    chk(r == 32'h0, "R7 status busy", r, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] r; int l;
    cfg_wr(2'd0, 32'h0000_0005);
    access(1'b0, 1'b0, 2'd2, 2'd1, 16'h0000, 32'h0, r, l);
    chk(l == 1 && cyc_n == 0, "R8 disabled cs latency/strobes", {l[15:0], cyc_n[15:0]}, 32'h0001_0000);
    chk(r == 32'h0, "R8 disabled cs rdata", r, 32'h0);
  endtask

  task automatic t_word8_write();
    logic [31:0] r; int l;
    cfg_wr(2'd1, 32'h0000_0021);
    cfg_wr(2'd0, 32'h0000_0005);
    access(1'b0, 1'b1, 2'd2, 2'd2, 16'h0003, 32'hDDCC_BBAA, r, l);
    chk(cyc_n == 4, "R4 word on 8-bit cycles", cyc_n, 4);
    chk(l == 25, "R6 latency word 8-bit", l, 25);
    chk(low_n == 12, "R6 strobe width", low_n, 12);
    for (int k = 0; k < 4; k++) begin
      chk(log_d[k] == {8'h00, 8'hAA + 8'(k * 8'h11)}, "R5 byte lane order", log_d[k], {8'h00, 8'hAA + 8'(k * 8'h11)});
      chk(log_ce[k] == 4'b1011, "R11 only cs2 low", log_ce[k], 4'b1011);
      chk(!log_cle[k] && !log_ale[k] && log_die[k], "R1 R2 R3 no latch/die", {log_cle[k], log_ale[k], log_die[k]}, 3'b001);
    end
  endtask

  task automatic t_word16_write();
    logic [31:0] r; int l;
    cfg_wr(2'd0, 32'h0000_0105);
    access(1'b0, 1'b1, 2'd2, 2'd0, 16'h0000, 32'h4433_2211, r, l);
    chk(cyc_n == 2, "R4 word on 16-bit cycles", cyc_n, 2);
    chk(l == 13, "R6 latency word 16-bit", l, 13);
    chk(log_d[0] == 16'h2211 && log_d[1] == 16'h4433, "R5 halfword lanes", {log_d[1], log_d[0]}, 32'h4433_2211);
    access(1'b0, 1'b1, 2'd0, 2'd0, 16'h0000, 32'h0000_00A5, r, l);
    chk(cyc_n == 1 && log_d[0] == 16'h00A5, "R4 byte on 16-bit", {cyc_n[15:0], log_d[0]}, 32'h0001_00A5);
  endtask

  task automatic t_latches();
    logic [31:0] r; int l;
    cfg_wr(2'd0, 32'h0000_0005);
    access(1'b0, 1'b1, 2'd0, 2'd0, 16'h0008, 32'h0000_005A, r, l);
    chk(log_ale[0] && !log_cle[0], "R1 ale from bit 3", {log_ale[0], log_cle[0]}, 2'b10);
    chk(log_d[0] == 16'h005A && l == 7, "R1 byte data/latency", {log_d[0], l[15:0]}, 32'h005A_0007);
    access(1'b0, 1'b1, 2'd0, 2'd0, 16'h0018, 32'h0000_0070, r, l);
    chk(log_cle[0] && !log_ale[0], "R2 cle priority", {log_ale[0], log_cle[0]}, 2'b01);
    access(1'b0, 1'b1, 2'd0, 2'd0, 16'h1000, 32'h0000_0001, r, l);
    chk(!log_die[0] && log_ce[0] == 4'b1110, "R3 second die select", {log_die[0], log_ce[0]}, 5'b01110);
  endtask

  task automatic t_reads();
    logic [31:0] r; int l;
    cfg_wr(2'd0, 32'h0000_0001);
    rd_pat = '{16'hEE11, 16'hEE22, 16'hEE33, 16'hEE44};
    access(1'b0, 1'b0, 2'd2, 2'd0, 16'h0000, 32'h0, r, l);
    chk(r == 32'h4433_2211, "R5 read 8-bit assembly", r, 32'h4433_2211);
    chk(l == 25 && cyc_n == 4, "R6 read latency", {l[15:0], cyc_n[15:0]}, 32'h0019_0004);
    rd_pat = '{16'hEE5A, 16'hEEC3, 16'h0, 16'h0};
    access(1'b0, 1'b0, 2'd1, 2'd0, 16'h0002, 32'h0, r, l);
    chk(r == 32'h0000_C35A && cyc_n == 2, "R4 R5 half read on 8-bit", r, 32'h0000_C35A);
    cfg_wr(2'd0, 32'h0000_0101);
    rd_pat = '{16'hBEEF, 16'hCAFE, 16'h0, 16'h0};
    access(1'b0, 1'b0, 2'd2, 2'd0, 16'h0000, 32'h0, r, l);
    chk(r == 32'hCAFE_BEEF, "R5 read 16-bit assembly", r, 32'hCAFE_BEEF);
  endtask

  task automatic t_timing2();
    logic [31:0] r; int l;
    cfg_wr(2'd0, 32'h0000_0001);
    cfg_wr(2'd1, 32'h0000_0200);
    access(1'b0, 1'b1, 2'd0, 2'd0, 16'h0000, 32'h0000_0033, r, l);
    chk(l == 6, "R6 latency hold=2", l, 6);
    chk(low_n == 1, "R6 strobe width P=0", low_n, 1);
  endtask

  initial begin
    #(200000 * 8);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_status();
    t_disabled();
    t_word8_write();
    t_word16_write();
    t_latches();
    t_reads();
    t_timing2();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule